// File: doc/BRIEF.md
# Asynchronous Serial Channel with Multiprocessor Bit

This block is one full-duplex asynchronous serial channel. Software writes a byte into a transmit holding register. When the transmitter is enabled, the byte moves into a shift register and goes out on `txd` as a frame. The frame has a low start bit, eight data bits with the least significant bit first, an optional multiprocessor (address/data) bit, an optional parity bit and one high stop bit. The receiver watches `rxd` and samples every bit at its middle using a 16x oversampling tick. Each received byte goes into a receive holding register, and the receiver flags overrun, framing and parity errors.

The control register holds several fields. The transmit-enable bit starts and stops the transmitter. Clearing it aborts a frame that is in flight, but the transmit-empty flag keeps its value. The `iostop` input holds transmit enable at zero while it is asserted. The clock-pin select bit is passed straight to an output that steers a shared pin outside the block. One control bit has two roles. A read returns the multiprocessor bit of the most recent received frame. A write of 0 to it clears all three error flags at once.

The bit rate is fixed. One oversampling tick occurs every `CLKS_PER_TICK` clocks, and each bit lasts 16 ticks.

Top module: `uart_mpb_chan`

## Requirements
- R1: After reset, transmit enable is 0, the clock-pin select is 0, the status register reads 0x01 (transmit-empty set, every other flag clear), and `txd` is high.
- R2: A transmitted frame is a low start bit, then 8 data bits LSB first, then the multiprocessor bit (control bit 6) if multiprocessor mode (control bit 2) is on, then a parity bit if parity (control bit 1) is on, then a high stop bit. The parity bit is the XOR of the data bits, inverted when odd parity (control bit 0) is set. Each bit lasts 16 ticks.
- R3: Writing transmit enable (control bit 5) to 0 during a frame ends the frame: `txd` is high from the second clock after the write and sends no further bits. A byte still held in the transmit register is sent once transmit enable is set again.
- R4: While transmit enable is 0, the transmit-empty flag (status bit 0) keeps its value.
- R5: While `iostop` is high, transmit enable reads 0 and a write of 1 to it has no effect. After `iostop` falls, the bit stays 0 until software writes it again.
- R6: A received byte is readable at address 3 and sets receive-full (status bit 7). A read of address 3 with `reg_rd` high clears receive-full.
- R7: With multiprocessor mode on, control bit 3 reads back the multiprocessor bit of the most recent stored frame.
- R8: A stop bit sampled low sets the framing-error flag (status bit 4). The receiver then waits for the line to return high before it looks for a new start bit.
- R9: With parity on, a received parity bit that differs from the one computed under R2 sets the parity-error flag (status bit 5). The byte is still stored.
- R10: A frame that completes while receive-full is set sets the overrun flag (status bit 6) and is discarded. The held byte is unchanged.
- R11: A control write with bit 3 equal to 0 clears the overrun, framing-error and parity-error flags together. A control write with bit 3 equal to 1 leaves them unchanged.
- R12: The `clkpin_alt` output equals control bit 4.
- R13: A write to the transmit register (address 2) clears transmit-empty. Transmit-empty is set again when the transmitter takes the byte to start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iostop | input | 1 | I/O-stop condition; holds transmit enable at 0 |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; at address 3 it pops the received byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| clkpin_alt | output | 1 | Shared-pin select: 0 external serial clock, 1 alternate end-of-transfer function |

## Verification
The assertions check, on every cycle, the rules that follow directly from register writes and receiver completions. These are: `iostop` keeping transmit enable low, transmit-empty holding while the transmitter is disabled, the error-clear write, overrun setting while the held byte stays intact, and `txd` returning high after an abort. The bench scenarios show what only becomes visible across a whole frame. This covers bit order and the placement of the multiprocessor and parity bits on the line, the mid-bit sampling of received frames, recovery after a broken stop bit, and a held byte being sent after transmit enable is set again.

// File: rtl/uart_mpb_pkg.sv
package uart_mpb_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_TXD  = 2'd2;
    localparam logic [ADDR_W-1:0] A_RXD  = 2'd3;

    // control register bit positions
    localparam int B_PARODD = 0;
    localparam int B_PAREN  = 1;
    localparam int B_MPMODE = 2;
    localparam int B_MPB    = 3;
    localparam int B_CKALT  = 4;
    localparam int B_TXEN   = 5;
    localparam int B_TXMPB  = 6;

    typedef struct packed {
        logic tx_mpb;
        logic tx_en;
        logic ck_alt;
        logic mp_mode;
        logic par_en;
        logic par_odd;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic overrun;
        logic par_err;
        logic frm_err;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              par_bad;
        logic              stop_bad;
    } rx_frame_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_MPB, TX_PAR, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_MPB, RX_PAR, RX_STOP, RX_HOLD
    } rx_st_e;

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/uart_mpb_tick.sv
module uart_mpb_tick #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_mpb_tx.sv
module uart_mpb_tx
    import uart_mpb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              mp_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              req,
    input  logic              mpb_in,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              txd
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

    tx_st_e            st;
    tx_st_e            after_data, after_mpb;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              mpb_r, par_r, line;
    logic              bit_end;

    assign bit_end = tick && (tcnt == T_LAST);
    assign take    = (st == TX_IDLE) && en && req;
    assign txd     = line;

    always_comb begin
        after_mpb  = par_en  ? TX_PAR : TX_STOP;
        after_data = mp_mode ? TX_MPB : after_mpb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            line  <= 1'b1;
            tcnt  <= '0;
            bidx  <= '0;
            sh    <= '0;
            mpb_r <= 1'b0;
            par_r <= 1'b0;
        end else if (!en) begin
            st   <= TX_IDLE;
            line <= 1'b1;
            tcnt <= '0;
        end else if (take) begin
            sh    <= data;
            mpb_r <= mpb_in;
            par_r <= par_bit(data, par_odd);
            st    <= TX_START;
            line  <= 1'b0;
            tcnt  <= '0;
            bidx  <= '0;
        end else if (st != TX_IDLE && tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (bit_end) begin
                case (st)
                    TX_START: begin
                        st   <= TX_DATA;
                        line <= sh[0];
                        sh   <= sh >> 1;
                        bidx <= '0;
                    end
                    TX_DATA: begin
                        if (bidx == B_LAST) begin
                            st <= after_data;
                            if (after_data == TX_MPB)      line <= mpb_r;
                            else if (after_data == TX_PAR) line <= par_r;
                            else                           line <= 1'b1;
                        end else begin
                            bidx <= bidx + 1'b1;
                            line <= sh[0];
                            sh   <= sh >> 1;
                        end
                    end
                    TX_MPB: begin
                        st   <= after_mpb;
                        line <= par_en ? par_r : 1'b1;
                    end
                    TX_PAR: begin
                        st   <= TX_STOP;
                        line <= 1'b1;
                    end
                    default: begin
                        st   <= TX_IDLE;
                        line <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_mpb_rx.sv
module uart_mpb_rx
    import uart_mpb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      mp_mode,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] T_MID  = CW'(OVS / 2 - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

    rx_st_e            st;
    rx_st_e            after_data, after_mpb;
    logic [1:0]        sync;
    logic              rxs;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              mpb_r, par_bad_r;
    logic              bit_end, mid_end;

    assign rxs     = sync[1];
    assign bit_end = tick && (tcnt == T_LAST);
    assign mid_end = tick && (tcnt == T_MID);

    always_comb begin
        after_mpb  = par_en  ? RX_PAR : RX_STOP;
        after_data = mp_mode ? RX_MPB : after_mpb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
        end else begin
            sync <= {sync[0], rxd};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            sh        <= '0;
            mpb_r     <= 1'b0;
            par_bad_r <= 1'b0;
            done      <= 1'b0;
            frame     <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (!rxs) begin
                        st   <= RX_START;
                        tcnt <= '0;
                    end
                end
                RX_HOLD: begin
                    if (rxs) st <= RX_IDLE;
                end
                RX_START: begin
                    if (tick) begin
                        if (mid_end) begin
                            tcnt      <= '0;
                            bidx      <= '0;
                            mpb_r     <= 1'b0;
                            par_bad_r <= 1'b0;
                            st        <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        tcnt <= bit_end ? '0 : tcnt + 1'b1;
                        if (bit_end) begin
                            case (st)
                                RX_DATA: begin
                                    sh <= {rxs, sh[DATA_W-1:1]};
                                    if (bidx == B_LAST) st <= after_data;
                                    else                bidx <= bidx + 1'b1;
                                end
                                RX_MPB: begin
                                    mpb_r <= rxs;
                                    st    <= after_mpb;
                                end
                                RX_PAR: begin
                                    par_bad_r <= (rxs != par_bit(sh, par_odd));
                                    st        <= RX_STOP;
                                end
                                default: begin
                                    done           <= 1'b1;
                                    frame.data     <= sh;
                                    frame.mpb      <= mpb_r;
                                    frame.par_bad  <= par_bad_r;
                                    frame.stop_bad <= !rxs;
                                    st             <= rxs ? RX_IDLE : RX_HOLD;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_mpb_regs.sv
module uart_mpb_regs
    import uart_mpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iostop,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output stat_t             stat,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_byte,
    input  logic              tx_take,
    input  logic              rx_done,
    input  rx_frame_t         rx_frame
);
    logic wr_ctrl, wr_txd, rd_rxd;
    logic mpb_last;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_txd  = wr_en && (addr == A_TXD);
    assign rd_rxd  = rd_en && (addr == A_RXD);
    assign tx_req  = !stat.tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl          <= '0;
            stat          <= '0;
            stat.tx_empty <= 1'b1;
            tx_data       <= '0;
            rx_byte       <= '0;
            mpb_last      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.tx_mpb  <= wdata[B_TXMPB];
                ctrl.tx_en   <= wdata[B_TXEN];
                ctrl.ck_alt  <= wdata[B_CKALT];
                ctrl.mp_mode <= wdata[B_MPMODE];
                ctrl.par_en  <= wdata[B_PAREN];
                ctrl.par_odd <= wdata[B_PARODD];
            end
            if (iostop) ctrl.tx_en <= 1'b0;

            if (tx_take) stat.tx_empty <= 1'b1;
            if (wr_txd) begin
                tx_data       <= wdata;
                stat.tx_empty <= 1'b0;
            end

            if (rd_rxd) stat.rx_full <= 1'b0;
            if (rx_done) begin
                if (stat.rx_full) begin
                    stat.overrun <= 1'b1;
                end else begin
                    rx_byte      <= rx_frame.data;
                    mpb_last     <= rx_frame.mpb;
                    stat.rx_full <= 1'b1;
                end
                if (rx_frame.par_bad)  stat.par_err <= 1'b1;
                if (rx_frame.stop_bad) stat.frm_err <= 1'b1;
            end

            if (wr_ctrl && !wdata[B_MPB]) begin
                stat.overrun <= 1'b0;
                stat.par_err <= 1'b0;
                stat.frm_err <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_TXMPB]  = ctrl.tx_mpb;
                rdata[B_TXEN]   = ctrl.tx_en;
                rdata[B_CKALT]  = ctrl.ck_alt;
                rdata[B_MPB]    = ctrl.mp_mode & mpb_last;
                rdata[B_MPMODE] = ctrl.mp_mode;
                rdata[B_PAREN]  = ctrl.par_en;
                rdata[B_PARODD] = ctrl.par_odd;
            end
            A_STAT:  rdata = {stat.rx_full, stat.overrun, stat.par_err, stat.frm_err,
                              3'b000, stat.tx_empty};
            A_TXD:   rdata = tx_data;
            default: rdata = rx_byte;
        endcase
    end
endmodule

// File: rtl/uart_mpb_chan.sv
module uart_mpb_chan
    import uart_mpb_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVS           = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iostop,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              txd,
    input  logic              rxd,
    output logic              clkpin_alt
);
    logic              tick;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic              tx_req, tx_take, rx_done;
    logic [DATA_W-1:0] tx_data, rx_byte;
    rx_frame_t         rx_frame;

    assign clkpin_alt = ctrl_q.ck_alt;

    uart_mpb_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uart_mpb_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .iostop   (iostop),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl_q),
        .stat     (stat_q),
        .tx_req   (tx_req),
        .tx_data  (tx_data),
        .rx_byte  (rx_byte),
        .tx_take  (tx_take),
        .rx_done  (rx_done),
        .rx_frame (rx_frame)
    );

    uart_mpb_tx #(.OVS(OVS)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (ctrl_q.tx_en),
        .mp_mode (ctrl_q.mp_mode),
        .par_en  (ctrl_q.par_en),
        .par_odd (ctrl_q.par_odd),
        .req     (tx_req),
        .mpb_in  (ctrl_q.tx_mpb),
        .data    (tx_data),
        .take    (tx_take),
        .txd     (txd)
    );

    uart_mpb_rx #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .rxd     (rxd),
        .mp_mode (ctrl_q.mp_mode),
        .par_en  (ctrl_q.par_en),
        .par_odd (ctrl_q.par_odd),
        .done    (rx_done),
        .frame   (rx_frame)
    );
endmodule

// File: rtl/uart_mpb_chan_sva.sv
module uart_mpb_chan_sva
    import uart_mpb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iostop,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              tx_en,
    input logic              tx_empty,
    input logic              txd,
    input logic              rx_done,
    input logic              rx_full,
    input logic              overrun,
    input logic              par_err,
    input logic              frm_err,
    input logic [DATA_W-1:0] rx_byte
);
    assert_iostop_blocks_txen_R5: assert property (@(posedge clk) disable iff (rst)
        iostop |=> !tx_en);

    assert_abort_line_high_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |=> txd);

    assert_empty_held_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !(reg_wr && reg_addr == A_TXD)) |=> $stable(tx_empty));

    assert_txd_write_fills_R13: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_TXD) |=> !tx_empty);

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[B_MPB]) |=> !(overrun || par_err || frm_err));

    assert_overrun_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full && !(reg_wr && reg_addr == A_CTRL)) |=> overrun);

    assert_overrun_keeps_byte_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full) |=> $stable(rx_byte));

    assert_full_from_frame_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(rx_done));
endmodule

bind uart_mpb_chan uart_mpb_chan_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .iostop    (iostop),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_en     (ctrl_q.tx_en),
    .tx_empty  (stat_q.tx_empty),
    .txd       (txd),
    .rx_done   (rx_done),
    .rx_full   (stat_q.rx_full),
    .overrun   (stat_q.overrun),
    .par_err   (stat_q.par_err),
    .frm_err   (stat_q.frm_err),
    .rx_byte   (rx_byte)
);

// File: tb/uart_mpb_chan_tb.sv
module uart_mpb_chan_tb;
    localparam int CPT = 4;
    localparam int BIT = 16 * CPT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iostop = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       txd;
    logic       rxd = 1'b1;
    logic       clkpin_alt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    uart_mpb_chan #(.CLKS_PER_TICK(CPT), .OVS(16)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .iostop     (iostop),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .txd        (txd),
        .rxd        (rxd),
        .clkpin_alt (clkpin_alt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        if (pop) begin
            reg_rd = 1'b1;
            @(negedge clk);
            reg_rd = 1'b0;
        end
    endtask

    // capture nbits of a transmitted frame, each at mid-bit
    task automatic cap_tx(input int nbits, output logic [15:0] v);
        int w = 0;
        v = '1;
        while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        repeat (BIT / 2) @(negedge clk);
        v[0] = txd;
        for (int i = 1; i < nbits; i++) begin
            repeat (BIT) @(negedge clk);
            v[i] = txd;
        end
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input bit has_mp, input bit mpb,
                           input bit has_par, input bit pb, input bit stopb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (has_mp) begin rxd = mpb; repeat (BIT) @(negedge clk); end
        if (has_par) begin rxd = pb; repeat (BIT) @(negedge clk); end
        rxd = stopb;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(2'd1, 0, d); chk("R1 status after reset", d, 8'h01);
        rd(2'd0, 0, d); chk("R1 tx enable after reset", d[5], 0);
        chk("R1 clock-pin select after reset", clkpin_alt, 0);
        chk("R1 txd idle after reset", txd, 1);
    endtask

    task automatic t_tx_frames;
        logic [7:0] d;
        logic [15:0] v;
        int lows = 0;
        wr(2'd2, 8'h3C);
        rd(2'd1, 0, d); chk("R13 empty cleared by write", d[0], 0);
        for (int i = 0; i < 40; i++) begin
            repeat (8) @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R4 disabled transmitter stays idle", lows, 0);
        rd(2'd1, 0, d); chk("R4 empty held while disabled", d[0], 0);
        wr(2'd0, 8'h28);
        cap_tx(10, v);
        chk("R2 plain frame bits", v[9:0], {1'b1, 8'h3C, 1'b0});
        rd(2'd1, 0, d); chk("R13 empty set after take", d[0], 1);
        // multiprocessor bit 1, odd parity: ^A5 = 0 so parity bit 1
        wr(2'd0, 8'h6F);
        wr(2'd2, 8'hA5);
        cap_tx(12, v);
        chk("R2 frame with mp and odd parity", v[11:0], {1'b1, 1'b1, 1'b1, 8'hA5, 1'b0});
        wr(2'd0, 8'h08);
    endtask

    task automatic t_abort;
        logic [7:0] d;
        logic [15:0] v;
        int lows = 0;
        int w = 0;
        wr(2'd0, 8'h28);
        wr(2'd2, 8'h00);
        while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        repeat (3 * BIT) @(negedge clk);
        wr(2'd2, 8'h5A);
        rd(2'd1, 0, d); chk("R13 empty cleared during frame", d[0], 0);
        wr(2'd0, 8'h08);
        @(negedge clk);
        rd(2'd1, 0, d); chk("R4 empty kept after disable", d[0], 0);
        for (int i = 0; i < 48; i++) begin
            repeat (16) @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R3 aborted frame sends no more bits", lows, 0);
        rd(2'd1, 0, d); chk("R4 empty still held", d[0], 0);
        wr(2'd0, 8'h28);
        cap_tx(10, v);
        chk("R3 held byte sent after re-enable", v[9:0], {1'b1, 8'h5A, 1'b0});
        wr(2'd0, 8'h08);
    endtask

    task automatic t_iostop;
        logic [7:0] d;
        wr(2'd0, 8'h28);
        rd(2'd0, 0, d); chk("R5 enable set before stop", d[5], 1);
        @(negedge clk); iostop = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd0, 0, d); chk("R5 stop clears enable", d[5], 0);
        wr(2'd0, 8'h28);
        rd(2'd0, 0, d); chk("R5 write ignored during stop", d[5], 0);
        @(negedge clk); iostop = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd0, 0, d); chk("R5 enable stays clear after stop", d[5], 0);
        wr(2'd0, 8'h28);
        rd(2'd0, 0, d); chk("R5 enable settable again", d[5], 1);
        wr(2'd0, 8'h08);
    endtask

    task automatic t_rx_basic;
        logic [7:0] d;
        wr(2'd0, 8'h08);
        send_rx(8'h96, 0, 0, 0, 0, 1);
        rd(2'd1, 0, d); chk("R6 full after frame", d, 8'h81);
        rd(2'd3, 1, d); chk("R6 received byte", d, 8'h96);
        rd(2'd1, 0, d); chk("R6 full cleared by read", d[7], 0);
    endtask

    task automatic t_mpb;
        logic [7:0] d;
        wr(2'd0, 8'h0C);
        send_rx(8'h31, 1, 1, 0, 0, 1);
        rd(2'd0, 0, d); chk("R7 mp bit 1 read back", d[3], 1);
        rd(2'd3, 1, d); chk("R7 byte with mp bit", d, 8'h31);
        send_rx(8'hC4, 1, 0, 0, 0, 1);
        rd(2'd0, 0, d); chk("R7 mp bit 0 read back", d[3], 0);
        rd(2'd3, 1, d); chk("R7 second byte", d, 8'hC4);
        rd(2'd1, 0, d); chk("R7 no errors", d[6:4], 0);
    endtask

    task automatic t_parity_clear;
        logic [7:0] d;
        wr(2'd0, 8'h0A);
        send_rx(8'h07, 0, 0, 1, 1, 1);
        rd(2'd1, 0, d); chk("R9 good even parity no error", d[5], 0);
        rd(2'd3, 1, d);
        send_rx(8'h07, 0, 0, 1, 0, 1);
        rd(2'd1, 0, d); chk("R9 bad parity flagged", d[5], 1);
        rd(2'd3, 1, d); chk("R9 byte still stored", d, 8'h07);
        wr(2'd0, 8'h0A);
        rd(2'd1, 0, d); chk("R11 write of 1 keeps error", d[5], 1);
        wr(2'd0, 8'h02);
        rd(2'd1, 0, d); chk("R11 write of 0 clears error", d[5], 0);
    endtask

    task automatic t_frame_err;
        logic [7:0] d;
        wr(2'd0, 8'h08);
        send_rx(8'h55, 0, 0, 0, 0, 0);
        rd(2'd1, 0, d); chk("R8 framing error flagged", d[4], 1);
        rd(2'd3, 1, d);
        send_rx(8'h12, 0, 0, 0, 0, 1);
        rd(2'd3, 1, d); chk("R8 receiver recovers after bad stop", d, 8'h12);
        wr(2'd0, 8'h00);
        rd(2'd1, 0, d); chk("R11 framing error cleared", d[4], 0);
    endtask

    task automatic t_overrun;
        logic [7:0] d;
        wr(2'd0, 8'h08);
        send_rx(8'hAA, 0, 0, 0, 0, 1);
        send_rx(8'h55, 0, 0, 0, 0, 0);
        rd(2'd1, 0, d); chk("R10 overrun and framing set", d, 8'hD1);
        rd(2'd3, 1, d); chk("R10 held byte kept", d, 8'hAA);
        wr(2'd0, 8'h00);
        rd(2'd1, 0, d); chk("R11 all error flags cleared", d, 8'h01);
    endtask

    task automatic t_clkpin;
        wr(2'd0, 8'h18);
        @(negedge clk);
        chk("R12 pin select follows bit", clkpin_alt, 1);
        wr(2'd0, 8'h08);
        @(negedge clk);
        chk("R12 pin select cleared", clkpin_alt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_frames();
        t_abort();
        t_iostop();
        t_rx_basic();
        t_mpb();
        t_parity_clear();
        t_frame_err();
        t_overrun();
        t_clkpin();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule